// File: doc/BRIEF.md
# Wiper Tap Switch Sequencer

This block drives the switch network of a dual digitally controlled resistor string. Each channel keeps a stored wiper code and turns it into a one-hot enable over the tap switches of its string. When a code changes, the new tap switch closes for a set number of clocks before the old one opens. The wiper therefore never floats between taps. Two further controls serve the analog array: one connects the string end to end, and one shunts the wiper to the low terminal through a resistor.

A single active-low run control places both channels in a low-power state. The string is opened, the shunt closes and every tap switch opens, but the stored codes stay intact and can still be written. When the control returns high, the string is reconnected first. One clock later the stored tap closes and the shunt releases. A supply-fault pulse that arrives while the run control is low resets both stored codes to mid-scale.

Top module: `wiper_tap_sequencer`

## Requirements
- R1: The stored code of channel c (0 = lowest) selects bit `c*2^CODE_W + code` of `tap_en`: code 0 selects the switch next to the low terminal and the all-ones code the one next to the high terminal. Higher codes select higher bits.
- R2: After reset both stored codes are mid-scale (0x80 at the default width). Only the mid-scale tap of each channel is enabled, `string_en` is 1 and `shunt_en` is 0.
- R3: A write (`code_wr[c]` high, code taken from `code_in[c*CODE_W +: CODE_W]`) stores the code on that clock edge. On the next edge an overlap starts in which both the old tap and the new tap are enabled for `OVERLAP_CLKS` cycles. After the overlap only the new tap is enabled.
- R4: While running and not in an overlap, exactly one tap per channel is enabled.
- R5: A write that lands during an overlap does not disturb it. When the overlap ends, the latest stored code starts a new overlap, and codes overwritten in between are never applied.
- R6: Writing the code that is already applied causes no overlap and no change on `tap_en`.
- R7: One cycle after `pot_enable` is sampled low, `string_en` is 0, `shunt_en` is 1 and all of `tap_en` is 0, for both channels together.
- R8: Stored codes are kept through the shutdown state and writes are still accepted there. On exit each channel enables its stored tap directly, with no overlap.
- R9: On exit from shutdown, the first cycle has `string_en` 1, `shunt_en` still 1 and no tap enabled. The next cycle has `shunt_en` 0 and the stored taps enabled.
- R10: `supply_fault` sampled high together with `pot_enable` low sets both stored codes to mid-scale, and it wins over a write on the same edge. With `pot_enable` high it has no effect.
- R11: The channels sequence independently, so a change on one channel leaves the other's enables unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| code_wr | input | NUM_CH | Per-channel code write strobe |
| code_in | input | NUM_CH*CODE_W | Packed new codes, channel 0 in the low bits |
| pot_enable | input | 1 | Run control; 0 requests shutdown |
| supply_fault | input | 1 | Supply brownout pulse |
| tap_en | output | NUM_CH*2^CODE_W | Tap switch enables, channel 0 in the low bits |
| string_en | output | 1 | End-to-end string connect, shared by both channels |
| shunt_en | output | 1 | Wiper-to-low shunt enable, shared by both channels |

## Verification
The bench uses the default build: two channels, 8-bit codes and a two-clock overlap. With a two-cycle overlap, a write can land inside an overlap that is already running, so the skip-to-latest rule of R5 can be observed cycle by cycle. The full 256-wide vector per channel lets the bench exercise the end codes 0x00 and 0xFF. The bench also drives shutdown and exit in the middle of an overlap and a supply fault in both run states.

// File: rtl/tapseq_pkg.sv
package tapseq_pkg;

    // Operating state shared by both channels
    typedef enum logic [1:0] {
        MODE_RUN  = 2'd0,
        MODE_SHUT = 2'd1,
        MODE_WAKE = 2'd2
    } mode_e;

    // Per-channel switching phase
    typedef enum logic {
        PH_STEADY  = 1'b0,
        PH_OVERLAP = 1'b1
    } phase_e;

    function automatic int unsigned mid_code(int unsigned width);
        return 32'd1 << (width - 1);
    endfunction

endpackage

// File: rtl/tapseq_code_store.sv
module tapseq_code_store #(
    parameter int NUM_CH = 2,
    parameter int CODE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_CH-1:0]        code_wr,
    input  logic [NUM_CH*CODE_W-1:0] code_in,
    input  logic                     pot_enable,
    input  logic                     supply_fault,
    output logic [NUM_CH*CODE_W-1:0] code_q
);
    localparam logic [CODE_W-1:0] MID = CODE_W'(tapseq_pkg::mid_code(CODE_W));

    logic fault_preset;
    assign fault_preset = supply_fault && !pot_enable;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_slot
        logic [CODE_W-1:0] slot_q;
        always_ff @(posedge clk) begin
            if (rst || fault_preset) begin
                slot_q <= MID;
            end else if (code_wr[c]) begin
                slot_q <= code_in[c*CODE_W +: CODE_W];
            end
        end
        assign code_q[c*CODE_W +: CODE_W] = slot_q;
    end

    // R10: a fault during shutdown presets every slot
    a_r10_fault_preset: assert property (@(posedge clk) disable iff (rst)
        (supply_fault && !pot_enable) |=> (code_q == {NUM_CH{MID}}));

    // R10: a fault while running leaves the slots alone
    a_r10_fault_ignored: assert property (@(posedge clk) disable iff (rst)
        (pot_enable && code_wr == '0) |=> $stable(code_q));

endmodule

// File: rtl/tapseq_mode_ctrl.sv
module tapseq_mode_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic pot_enable,
    output logic run,
    output logic string_en,
    output logic shunt_en
);
    import tapseq_pkg::*;

    mode_e mode_q, mode_d;

    always_comb begin
        mode_d = mode_q;
        if (!pot_enable) begin
            mode_d = MODE_SHUT;
        end else begin
            unique case (mode_q)
                MODE_SHUT: mode_d = MODE_WAKE;
                MODE_WAKE: mode_d = MODE_RUN;
                default:   mode_d = MODE_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_RUN;
        else     mode_q <= mode_d;
    end

    assign run       = (mode_q == MODE_RUN);
    assign string_en = (mode_q != MODE_SHUT);
    assign shunt_en  = (mode_q != MODE_RUN);

    // R7: shutdown follows the control one clock later
    a_r7_enter_shut: assert property (@(posedge clk) disable iff (rst)
        !pot_enable |=> (!string_en && shunt_en));

    // R9: the string reconnects while the shunt is still held and taps are off
    a_r9_string_first: assert property (@(posedge clk) disable iff (rst)
        $rose(string_en) |-> (shunt_en && !run));

    // R9: the shunt releases only after a cycle of connected string
    a_r9_shunt_after: assert property (@(posedge clk) disable iff (rst)
        $fell(shunt_en) |-> (string_en && $past(string_en)));

endmodule

// File: rtl/tapseq_channel.sv
module tapseq_channel #(
    parameter int CODE_W       = 8,
    parameter int OVERLAP_CLKS = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    run,
    input  logic [CODE_W-1:0]       target,
    output logic [(1<<CODE_W)-1:0]  tap_en
);
    import tapseq_pkg::*;

    localparam int TAPS  = 1 << CODE_W;
    localparam int CNT_W = (OVERLAP_CLKS > 1) ? $clog2(OVERLAP_CLKS) : 1;
    localparam logic [CNT_W-1:0]  LAST = CNT_W'(OVERLAP_CLKS - 1);
    localparam logic [CODE_W-1:0] MID  = CODE_W'(mid_code(CODE_W));
    localparam logic [TAPS-1:0]   ONE  = TAPS'(1);

    typedef struct packed {
        phase_e            ph;
        logic [CODE_W-1:0] cur;
        logic [CODE_W-1:0] nxt;
        logic [CNT_W-1:0]  cnt;
    } ch_state_t;

    ch_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (!run) begin
            // Taps are open: follow the stored code without sequencing
            st_d.ph  = PH_STEADY;
            st_d.cur = target;
            st_d.nxt = target;
            st_d.cnt = '0;
        end else if (st_q.ph == PH_STEADY) begin
            if (target != st_q.cur) begin
                st_d.ph  = PH_OVERLAP;
                st_d.nxt = target;
                st_d.cnt = '0;
            end
        end else begin
            if (st_q.cnt == LAST) begin
                st_d.ph  = PH_STEADY;
                st_d.cur = st_q.nxt;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{ph: PH_STEADY, cur: MID, nxt: MID, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        tap_en = '0;
        if (run) begin
            tap_en = ONE << st_q.cur;
            if (st_q.ph == PH_OVERLAP) tap_en = tap_en | (ONE << st_q.nxt);
        end
    end

    // R4: a single closed switch outside an overlap
    a_r4_single_tap: assert property (@(posedge clk) disable iff (rst)
        (run && st_q.ph == PH_STEADY) |-> $onehot(tap_en));

    // R3: two switches closed during an overlap
    a_r3_pair_closed: assert property (@(posedge clk) disable iff (rst)
        (run && st_q.ph == PH_OVERLAP) |-> ($countones(tap_en) == 2));

    // R3: every change while running keeps a closed switch in common
    a_r3_make_before_break: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && tap_en != $past(tap_en)) |-> ((tap_en & $past(tap_en)) != '0));

    // R5: the incoming tap is frozen for the whole overlap
    a_r5_target_frozen: assert property (@(posedge clk) disable iff (rst)
        (run && st_q.ph == PH_OVERLAP) |=> (!run || st_q.ph == PH_STEADY || st_q.nxt == $past(st_q.nxt)));

endmodule

// File: rtl/wiper_tap_sequencer.sv
module wiper_tap_sequencer #(
    parameter int NUM_CH       = 2,
    parameter int CODE_W       = 8,
    parameter int OVERLAP_CLKS = 2
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [NUM_CH-1:0]               code_wr,
    input  logic [NUM_CH*CODE_W-1:0]        code_in,
    input  logic                            pot_enable,
    input  logic                            supply_fault,
    output logic [NUM_CH*(1<<CODE_W)-1:0]   tap_en,
    output logic                            string_en,
    output logic                            shunt_en
);
    localparam int TAPS = 1 << CODE_W;

    logic [NUM_CH*CODE_W-1:0] code_q;
    logic                     run;

    tapseq_code_store #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_store (
        .clk          (clk),
        .rst          (rst),
        .code_wr      (code_wr),
        .code_in      (code_in),
        .pot_enable   (pot_enable),
        .supply_fault (supply_fault),
        .code_q       (code_q)
    );

    tapseq_mode_ctrl u_mode (
        .clk        (clk),
        .rst        (rst),
        .pot_enable (pot_enable),
        .run        (run),
        .string_en  (string_en),
        .shunt_en   (shunt_en)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        tapseq_channel #(.CODE_W(CODE_W), .OVERLAP_CLKS(OVERLAP_CLKS)) u_ch (
            .clk    (clk),
            .rst    (rst),
            .run    (run),
            .target (code_q[c*CODE_W +: CODE_W]),
            .tap_en (tap_en[c*TAPS +: TAPS])
        );
    end

    // R7: an open string never coexists with a closed tap switch
    a_r7_taps_open: assert property (@(posedge clk) disable iff (rst)
        !string_en |-> (tap_en == '0 && shunt_en));

endmodule

// File: tb/tb_wiper_tap_sequencer.sv
module tb_wiper_tap_sequencer;
    localparam int NUM_CH = 2;
    localparam int CODE_W = 8;
    localparam int TAPS   = 1 << CODE_W;
    localparam int NROWS  = 33;

    logic                          clk = 1'b0;
    logic                          rst = 1'b1;
    logic [NUM_CH-1:0]             code_wr = '0;
    logic [NUM_CH*CODE_W-1:0]      code_in = '0;
    logic                          pot_enable = 1'b1;
    logic                          supply_fault = 1'b0;
    logic [NUM_CH*TAPS-1:0]        tap_en;
    logic                          string_en;
    logic                          shunt_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    wiper_tap_sequencer #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .OVERLAP_CLKS(2)) dut (
        .clk(clk), .rst(rst), .code_wr(code_wr), .code_in(code_in),
        .pot_enable(pot_enable), .supply_fault(supply_fault),
        .tap_en(tap_en), .string_en(string_en), .shunt_en(shunt_en)
    );

    typedef struct packed {
        logic [1:0] wr;
        logic [7:0] c0;
        logic [7:0] c1;
        logic       en;
        logic       bo;
        logic       off;
        logic [7:0] a0;
        logic [7:0] b0;
        logic [7:0] a1;
        logic [7:0] b1;
        logic       str;
        logic       shn;
        logic [3:0] req;
    } row_t;

    // inputs for one edge, then expected outputs after it
    localparam row_t VEC [NROWS] = '{
        '{2'b01, 8'h90, 8'h00, 1'b1, 1'b0, 1'b0, 8'h80, 8'h80, 8'h80, 8'h80, 1'b1, 1'b0, 4'd3},  // R3 stored, not yet moved
        '{2'b00, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 8'h80, 8'h90, 8'h80, 8'h80, 1'b1, 1'b0, 4'd3},  // R3 overlap 1
        '{2'b00, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 8'h80, 8'h90, 8'h80, 8'h80, 1'b1, 1'b0, 4'd3},  // R3 overlap 2
        '{2'b00, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 8'h90, 8'h90, 8'h80, 8'h80, 1'b1, 1'b0, 4'd4},  // R4 single
        '{2'b01, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 8'h90, 8'h90, 8'h80, 8'h80, 1'b1, 1'b0, 4'd5},
        '{2'b01, 8'h05, 8'h00, 1'b1, 1'b0, 1'b0, 8'h90, 8'h00, 8'h80, 8'h80, 1'b1, 1'b0, 4'd5},  // R5 write in overlap
        '{2'b01, 8'hFF, 8'h00, 1'b1, 1'b0, 1'b0, 8'h90, 8'h00, 8'h80, 8'h80, 1'b1, 1'b0, 4'd5},
        '{2'b00, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 8'h80, 8'h80, 1'b1, 1'b0, 4'd1},  // R1 lowest tap
        '{2'b00, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 8'hFF, 8'h80, 8'h80, 1'b1, 1'b0, 4'd5},  // R5 0x05 skipped
        '{2'b00, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 8'hFF, 8'h80, 8'h80, 1'b1, 1'b0, 4'd5},
        '{2'b00, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 8'hFF, 8'hFF, 8'h80, 8'h80, 1'b1, 1'b0, 4'd1},  // R1 highest tap
        '{2'b10, 8'h00, 8'h7F, 1'b1, 1'b0, 1'b0, 8'hFF, 8'hFF, 8'h80, 8'h80, 1'b1, 1'b0, 4'd11}, // R11
        '{2'b00, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 8'hFF, 8'hFF, 8'h80, 8'h7F, 1'b1, 1'b0, 4'd11},
        '{2'b00, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 8'hFF, 8'hFF, 8'h80, 8'h7F, 1'b1, 1'b0, 4'd11},
        '{2'b00, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 8'hFF, 8'hFF, 8'h7F, 8'h7F, 1'b1, 1'b0, 4'd11},
        '{2'b00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 4'd7},  // R7 shutdown
        '{2'b00, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 4'd10}, // R10 fault
        '{2'b01, 8'h33, 8'h00, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 4'd8},  // R8 write in shutdown
        '{2'b00, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 1'b1, 4'd9},  // R9 string first
        '{2'b00, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 8'h33, 8'h33, 8'h80, 8'h80, 1'b1, 1'b0, 4'd10}, // R10 ch1 at mid
        '{2'b00, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 8'h33, 8'h33, 8'h80, 8'h80, 1'b1, 1'b0, 4'd10}, // R10 ignored when running
        '{2'b00, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 8'h33, 8'h33, 8'h80, 8'h80, 1'b1, 1'b0, 4'd10},
        '{2'b00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 4'd7},
        '{2'b00, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 1'b1, 4'd9},
        '{2'b00, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 8'h33, 8'h33, 8'h80, 8'h80, 1'b1, 1'b0, 4'd8},  // R8 codes kept
        '{2'b01, 8'h40, 8'h00, 1'b1, 1'b0, 1'b0, 8'h33, 8'h33, 8'h80, 8'h80, 1'b1, 1'b0, 4'd3},
        '{2'b00, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 8'h33, 8'h40, 8'h80, 8'h80, 1'b1, 1'b0, 4'd3},
        '{2'b00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 4'd7},  // R7 mid-overlap
        '{2'b00, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 1'b1, 4'd9},
        '{2'b00, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 8'h40, 8'h40, 8'h80, 8'h80, 1'b1, 1'b0, 4'd8},  // R8 no overlap on exit
        '{2'b01, 8'h40, 8'h00, 1'b1, 1'b0, 1'b0, 8'h40, 8'h40, 8'h80, 8'h80, 1'b1, 1'b0, 4'd6},  // R6 same code
        '{2'b00, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 8'h40, 8'h40, 8'h80, 8'h80, 1'b1, 1'b0, 4'd6},
        '{2'b00, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 8'h40, 8'h40, 8'h80, 8'h80, 1'b1, 1'b0, 4'd6}
    };

    function automatic logic [TAPS-1:0] pair(input logic [7:0] a, input logic [7:0] b);
        return (TAPS'(1) << a) | (TAPS'(1) << b);
    endfunction

    task automatic check_out(input int req, input string tag, input logic off,
                             input logic [7:0] a0, input logic [7:0] b0,
                             input logic [7:0] a1, input logic [7:0] b1,
                             input logic str, input logic shn);
        logic [TAPS-1:0] e0, e1;
        e0 = off ? '0 : pair(a0, b0);
        e1 = off ? '0 : pair(a1, b1);
        checks++;
        if (tap_en[0 +: TAPS] !== e0) begin
            errors++;
            $display("FAIL R%0d %s ch0 taps: got %h expected %h", req, tag, tap_en[0 +: TAPS], e0);
        end
        checks++;
        if (tap_en[TAPS +: TAPS] !== e1) begin
            errors++;
            $display("FAIL R%0d %s ch1 taps: got %h expected %h", req, tag, tap_en[TAPS +: TAPS], e1);
        end
        checks++;
        if (string_en !== str || shunt_en !== shn) begin
            errors++;
            $display("FAIL R%0d %s string/shunt: got %b%b expected %b%b", req, tag,
                     string_en, shunt_en, str, shn);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_out(2, "R2 reset state", 1'b0, 8'h80, 8'h80, 8'h80, 8'h80, 1'b1, 1'b0);

        for (int i = 0; i < NROWS; i++) begin
            code_wr      = VEC[i].wr;
            code_in      = {VEC[i].c1, VEC[i].c0};
            pot_enable   = VEC[i].en;
            supply_fault = VEC[i].bo;
            @(negedge clk);
            check_out(int'(VEC[i].req), $sformatf("row %0d", i), VEC[i].off,
                      VEC[i].a0, VEC[i].b0, VEC[i].a1, VEC[i].b1, VEC[i].str, VEC[i].shn);
        end

        // R10: fault beats a same-edge write during shutdown
        code_wr = 2'b11; code_in = {8'h11, 8'h22}; pot_enable = 1'b0; supply_fault = 1'b1;
        @(negedge clk);
        code_wr = '0; supply_fault = 1'b0; pot_enable = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check_out(10, "R10 fault over write", 1'b0, 8'h80, 8'h80, 8'h80, 8'h80, 1'b1, 1'b0);

        // R2: reset in the middle of an overlap returns to mid-scale
        code_wr = 2'b01; code_in = {8'h00, 8'h10};
        @(negedge clk);
        code_wr = '0;
        @(negedge clk);
        check_out(3, "R3 overlap before reset", 1'b0, 8'h80, 8'h10, 8'h80, 8'h80, 1'b1, 1'b0);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check_out(2, "R2 reset mid-overlap", 1'b0, 8'h80, 8'h80, 8'h80, 8'h80, 1'b1, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule